// File: doc/BRIEF.md
# Bit Timing and Synchronization Unit for a CAN Controller

This block turns the system clock into the time base of a CAN bit. A prescaler cuts the clock into time quanta, and a small sequencer walks every bit through a one-quantum sync segment, a first phase segment and a second phase segment. At the boundary between the two phase segments it raises a one-clock sample strobe and presents the bit value read from the receive line. The bit stream layer above it consumes that strobe and bit. In return it tells the block whether the bus is idle.

While the bus is idle, a recessive-to-dominant transition on the receive line restarts the bit at once (hard synchronization). Inside a frame, a falling edge in the first phase segment means the transmitter is late, and the segment is stretched. A falling edge in the second phase segment means it is early, and that segment is cut short. Either correction is limited by the programmed jump width, and only one correction is made per bit. When triple sampling is enabled, the bit value is a majority vote over three quantum samples that end at the sample point.

The receive line is examined once per quantum, on the quantum tick. It must already be synchronous to `clk`.

Top module: `bit_timing_unit`

## Requirements
- R1: `tq_tick` is high for one clock in every 2*(`brp`+1) clocks. A quantum is the stretch between ticks, and `rx` is sampled on the clock edge that ends a tick cycle.
- R2: When no falling edge is seen, successive sample pulses are `tseg1`+`tseg2`+3 quanta apart, and `sample_pulse` is never high for two clocks in a row.
- R3: The sequencer is in exactly one of sync, phase 1 and phase 2. It moves only on quantum ticks, with at most one move per clock. The sample pulse follows the last quantum of phase 1, which is `tseg1`+1 quanta after the sync quantum when no correction is made.
- R4: A falling edge (previous quantum sample 1, current 0) seen while `bus_idle` is high makes that quantum the sync quantum. The next sample pulse then follows the quantum `tseg1`+1 quanta later.
- R5: With `bus_idle` low, a falling edge in the L-th quantum of phase 1 stretches phase 1 by min(L, `sjw`+1) quanta.
- R6: With `bus_idle` low, a falling edge in phase 2 moves the next sync quantum to the later of two quanta: the edge quantum itself, or the quantum `sjw`+1 earlier than the undisturbed one.
- R7: At most one correction (R5 or R6) is applied per bit. Any further falling edge in the same bit is ignored.
- R8: With `triple` low, `rx_bit` takes the `rx` sample of the last phase 1 quantum at the sample pulse and holds it until the next pulse.
- R9: With `triple` high, `rx_bit` is the majority of the `rx` samples from the last three quanta of phase 1.
- R10: After reset, `rx_bit` is 1 (recessive) and `sample_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brp | input | 6 | Prescale value; quantum = 2*(brp+1) clocks |
| sjw | input | 2 | Jump width; largest correction is sjw+1 quanta |
| tseg1 | input | 4 | Phase 1 length minus one, in quanta |
| tseg2 | input | 3 | Phase 2 length minus one, in quanta |
| triple | input | 1 | 1: majority of three samples, 0: single sample |
| bus_idle | input | 1 | High while the bus is idle; enables hard synchronization |
| rx | input | 1 | Receive line, synchronous to clk, 1 = recessive |
| tq_tick | output | 1 | One-clock pulse at the end of each quantum |
| sample_pulse | output | 1 | One-clock pulse at each sample point |
| rx_bit | output | 1 | Bit value decided at the latest sample point |

## Verification
The bench works quantum by quantum. It sweeps every late-edge position across phase 1 and every early-edge position across phase 2, for several segment lengths and both jump widths. A sequencer that did not clamp the correction would place the sample pulse too late or too early. One that stretched the wrong segment would shift the pulse by whole quanta. One that mishandled an early edge near the end of phase 2 would start the next bit in the wrong quantum. A second falling edge inside the same bit exposes a design that resynchronizes twice. Glitch patterns around the sample point show whether the majority vote and the single sample pick the right quanta. A one-off error in the sample history would flip the decided bit.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_t;

  // clocks in one time quantum
  function automatic int quantum_clocks(int prescale);
    return 2 * (prescale + 1);
  endfunction

  // largest correction in quanta
  function automatic int sjw_quanta(int jump);
    return jump + 1;
  endfunction

  // stretch of phase 1 for an edge late_by quanta after sync
  function automatic int late_extension(int late_by, int jump);
    int lim;
    lim = sjw_quanta(jump);
    return (late_by < lim) ? late_by : lim;
  endfunction

  function automatic logic majority3(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/bt_quantum_gen.sv
module bt_quantum_gen #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp,
  output logic             tq_tick
);
  localparam int CW = BRP_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last    = CW'(bt_pkg::quantum_clocks(int'(brp)) - 1);
  assign tq_tick = (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (tq_tick) cnt <= '0;
    else              cnt <= cnt + CW'(1);
  end

  // a quantum is never shorter than two clocks
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |=> !tq_tick);

endmodule

// File: rtl/bt_bit_sampler.sv
module bt_bit_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic triple,
  output logic edge_fall,
  output logic vote
);
  // hist[0]: previous quantum sample, hist[1]: the one before
  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hist <= 2'b11;
    else if (tick) hist <= {hist[0], rx};
  end

  assign edge_fall = hist[0] & ~rx;
  assign vote      = triple ? bt_pkg::majority3(rx, hist[0], hist[1]) : rx;

endmodule

// File: rtl/bt_segment_fsm.sv
module bt_segment_fsm #(
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             edge_fall,
  input  logic             bus_idle,
  input  logic [SJW_W-1:0] sjw,
  input  logic [TS1_W-1:0] tseg1,
  input  logic [TS2_W-1:0] tseg2,
  output logic             sample_strobe
);
  import bt_pkg::*;

  localparam int LW = ((TS1_W > TS2_W) ? TS1_W : TS2_W) + 2;
  localparam logic [LW-1:0] ONE = LW'(1);

  seg_t          seg;
  logic [LW-1:0] qcnt, len1, len2;
  logic          resynced;

  logic [LW-1:0] base1, base2, step_s, rem, ext, len2_eff;
  logic          hard, resync_ok, late, early, early_restart, early_cut;
  logic          go_sync, go_seg1, go_seg2;

  assign base1  = LW'(int'(tseg1) + 1);
  assign base2  = LW'(int'(tseg2) + 1);
  assign step_s = LW'(sjw_quanta(int'(sjw)));
  assign rem    = len2 - qcnt;
  assign ext    = LW'(late_extension(int'(qcnt) + 1, int'(sjw)));

  // edge classification, one decision per quantum tick
  assign hard          = tick & edge_fall & bus_idle;
  assign resync_ok     = tick & edge_fall & ~bus_idle & ~resynced;
  assign late          = resync_ok & (seg == SEG_PH1);
  assign early         = resync_ok & (seg == SEG_PH2);
  assign early_restart = early & (rem <= step_s);
  assign early_cut     = early & ~early_restart;
  assign len2_eff      = early_cut ? (len2 - step_s) : len2;

  // segment moves
  assign go_seg1 = hard | (tick & (seg == SEG_SYNC)) | early_restart;
  assign go_seg2 = tick & ~hard & ~late & (seg == SEG_PH1) & (qcnt == len1 - ONE);
  assign go_sync = tick & ~hard & ~early_restart & (seg == SEG_PH2) &
                   (qcnt == len2_eff - ONE);

  assign sample_strobe = go_seg2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg      <= SEG_SYNC;
      qcnt     <= '0;
      len1     <= ONE;
      len2     <= ONE;
      resynced <= 1'b0;
    end else if (go_seg1) begin
      seg      <= SEG_PH1;
      qcnt     <= '0;
      len1     <= base1;
      resynced <= 1'b0;
    end else if (go_seg2) begin
      seg  <= SEG_PH2;
      qcnt <= '0;
      len2 <= base2;
    end else if (go_sync) begin
      seg      <= SEG_SYNC;
      qcnt     <= '0;
      resynced <= 1'b0;
    end else if (tick) begin
      qcnt <= qcnt + ONE;
      if (late) begin
        len1     <= len1 + ext;
        resynced <= 1'b1;
      end
      if (early_cut) begin
        len2     <= len2_eff;
        resynced <= 1'b1;
      end
    end
  end

  // R3: at most one segment move per clock
  a_r3_single_move: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_sync, go_seg1, go_seg2}));

  // R3: the segment changes only on a quantum tick
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(seg));

  // R4: a hard sync starts phase 1 from its first quantum
  a_r4_hard_restart: assert property (@(posedge clk) disable iff (!rst_n)
    hard |=> (seg == SEG_PH1) && (qcnt == '0));

  // R5: phase 1 never grows by more than the jump width
  a_r5_ext_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_PH1) |-> (len1 <= base1 + step_s));

  // R6: phase 2 keeps at least one quantum after a cut
  a_r6_seg2_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_PH2) |-> (len2 != '0) && (qcnt < len2));

endmodule

// File: rtl/bit_timing_unit.sv
module bit_timing_unit #(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp,
  input  logic [SJW_W-1:0] sjw,
  input  logic [TS1_W-1:0] tseg1,
  input  logic [TS2_W-1:0] tseg2,
  input  logic             triple,
  input  logic             bus_idle,
  input  logic             rx,
  output logic             tq_tick,
  output logic             sample_pulse,
  output logic             rx_bit
);
  logic edge_fall;
  logic vote;
  logic sample_strobe;

  bt_quantum_gen #(.BRP_W(BRP_W)) u_qgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .brp     (brp),
    .tq_tick (tq_tick)
  );

  bt_bit_sampler u_samp (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tq_tick),
    .rx        (rx),
    .triple    (triple),
    .edge_fall (edge_fall),
    .vote      (vote)
  );

  bt_segment_fsm #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tq_tick),
    .edge_fall     (edge_fall),
    .bus_idle      (bus_idle),
    .sjw           (sjw),
    .tseg1         (tseg1),
    .tseg2         (tseg2),
    .sample_strobe (sample_strobe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_pulse <= 1'b0;
      rx_bit       <= 1'b1;
    end else begin
      sample_pulse <= sample_strobe;
      if (sample_strobe) rx_bit <= vote;
    end
  end

  // R2: the sample pulse is one clock wide
  a_r2_pulse_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |=> !sample_pulse);

  // R8: the decided bit changes only together with a sample pulse
  a_r8_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_pulse |-> $stable(rx_bit));

endmodule

// File: tb/sim_bit_timing_unit.sv
module sim_bit_timing_unit;
  localparam int CLK_PERIOD = 10;
  localparam int EDGE       = 4;
  localparam int MAXS       = 96;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] brp;
  logic [1:0] sjw;
  logic [3:0] tseg1;
  logic [2:0] tseg2;
  logic       triple, bus_idle, rx;
  logic       tq_tick, sample_pulse, rx_bit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic seq [0:MAXS-1];
  int   seq_len;
  int   pat  [0:31];
  logic pbit [0:31];
  int   npulse;
  logic seen_pulse, seen_bit;

  bit_timing_unit u0 (
    .clk(clk), .rst_n(rst_n), .brp(brp), .sjw(sjw), .tseg1(tseg1),
    .tseg2(tseg2), .triple(triple), .bus_idle(bus_idle), .rx(rx),
    .tq_tick(tq_tick), .sample_pulse(sample_pulse), .rx_bit(rx_bit)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx = 1'b1; bus_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one quantum sample, then read the outputs one clock after its tick
  task automatic step(logic v, logic idle);
    rx = v; bus_idle = idle;
    while (tq_tick !== 1'b1) @(negedge clk);
    @(negedge clk);
    seen_pulse = sample_pulse;
    seen_bit   = rx_bit;
  endtask

  task automatic fill(int lo, int hi, logic v);
    for (int i = lo; i <= hi; i++) if (i >= 0 && i < MAXS) seq[i] = v;
  endtask

  task automatic play();
    npulse = 0;
    for (int i = 0; i < seq_len; i++) begin
      step(seq[i], i <= EDGE);
      if (seen_pulse && npulse < 32) begin
        pat[npulse]  = i;
        pbit[npulse] = seen_bit;
        npulse++;
        @(negedge clk);
        check_eq("R2 pulse width", int'(sample_pulse), 0);
      end
    end
  endtask

  function automatic int after_slot(int k);
    for (int j = 0; j < npulse; j++) if (pat[j] > k) return j;
    return -1;
  endfunction

  function automatic int slot_step(int j);
    return (j < 0) ? -1 : pat[j];
  endfunction

  initial begin
    int n, nq, s, j, j2, b0, e_at, expv;
    brp = 6'd0; sjw = 2'd0; tseg1 = 4'd2; tseg2 = 3'd1; triple = 1'b0;
    do_reset();
    // R10 reset state
    check_eq("R10 pulse after reset", int'(sample_pulse), 0);
    check_eq("R10 bit after reset", int'(rx_bit), 1);

    // R1 quantum length sweep
    for (int b = 0; b < 6; b++) begin
      brp = 6'(b);
      do_reset();
      while (tq_tick !== 1'b1) @(negedge clk);
      n = 0;
      do begin @(negedge clk); n++; end while (tq_tick !== 1'b1);
      check_eq("R1 quantum clocks", n, 2 * (b + 1));
    end

    for (int b = 0; b < 2; b++)
    for (int t1 = 2; t1 <= 4; t1++)
    for (int t2 = 1; t2 <= 3; t2++)
    for (int sj = 0; sj < 2; sj++) begin
      brp = 6'(b); tseg1 = 4'(t1); tseg2 = 3'(t2); sjw = 2'(sj); triple = 1'b0;
      do_reset();
      nq = t1 + t2 + 3;
      s  = sj + 1;

      // R3 R4 hard sync, R2 spacing, R8 value
      fill(0, EDGE - 1, 1'b1); fill(EDGE, EDGE + 3 * nq, 1'b0);
      seq_len = EDGE + 3 * nq + 1;
      play();
      j = after_slot(EDGE);
      check_eq("R3 R4 first sample after hard sync", slot_step(j), EDGE + t1 + 1);
      j2 = after_slot(slot_step(j));
      check_eq("R2 undisturbed bit spacing", slot_step(j2) - slot_step(j), nq);
      check_eq("R8 single sample value", (j < 0) ? -1 : int'(pbit[j]), 0);

      // R5 late edge in every phase 1 position
      b0 = EDGE + nq;
      for (int l = 1; l <= t1 + 1; l++) begin
        fill(0, EDGE - 1, 1'b1); fill(EDGE, b0 - 1, 1'b0);
        fill(b0, b0 + l - 1, 1'b1); fill(b0 + l, b0 + 2 * nq, 1'b0);
        seq_len = b0 + 2 * nq + 1;
        play();
        expv = b0 + t1 + 1 + ((l < s) ? l : s);
        check_eq("R5 late edge sample step", slot_step(after_slot(b0)), expv);
      end

      // R6 early edge in every phase 2 position
      for (int p = 0; p <= t2; p++) begin
        e_at = EDGE + t1 + 2 + p;
        fill(0, EDGE - 1, 1'b1); seq[EDGE] = 1'b0;
        fill(EDGE + 1, e_at - 1, 1'b1); fill(e_at, e_at + 2 * nq, 1'b0);
        seq_len = e_at + 2 * nq + 1;
        play();
        expv = ((e_at > EDGE + nq - s) ? e_at : (EDGE + nq - s)) + t1 + 1;
        check_eq("R6 early edge sample step", slot_step(after_slot(e_at - 1)), expv);
        if (p == t2) begin
          j = after_slot(EDGE);
          check_eq("R8 single sample of a one", (j < 0) ? -1 : int'(pbit[j]), 1);
        end
      end

      // R7 second falling edge in the same bit is ignored
      fill(0, EDGE - 1, 1'b1); fill(EDGE, b0 - 1, 1'b0);
      seq[b0] = 1'b1; seq[b0 + 1] = 1'b0; seq[b0 + 2] = 1'b1;
      fill(b0 + 3, b0 + 2 * nq, 1'b0);
      seq_len = b0 + 2 * nq + 1;
      play();
      check_eq("R7 one correction per bit", slot_step(after_slot(b0)), b0 + t1 + 2);

      // R8 R9 sample choice: quanta (t1-1, t1, t1+1) after sync read (0, g, 1)
      if (sj == 0) begin
        for (int tr = 0; tr < 2; tr++)
        for (int g = 0; g < 2; g++) begin
          triple = tr[0];
          fill(0, EDGE - 1, 1'b1); fill(EDGE, EDGE + t1 - 1, 1'b0);
          seq[EDGE + t1] = g[0];
          fill(EDGE + t1 + 1, EDGE + nq, 1'b1);
          seq_len = EDGE + nq;
          play();
          j = after_slot(EDGE);
          expv = (tr == 1) ? (((0 + g + 1) >= 2) ? 1 : 0) : 1;
          check_eq(tr == 1 ? "R9 majority vote" : "R8 single sample point",
                   (j < 0) ? -1 : int'(pbit[j]), expv);
        end
        triple = 1'b0;
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule